// File: doc/BRIEF.md
# Configuration Register CRC Self-Test Engine

This block guards a bank of 16-bit configuration registers against silent corruption. A single-cycle trigger starts a walk through a fixed list of 22 register addresses. Each addressed word is read through a one-cycle-latency read port and shifted, most significant bit first, into a serial CRC-16 engine. The final entry of the walk is a register that software has loaded with the expected CRC of the first 21 words. An intact configuration therefore leaves a zero remainder, and any other remainder raises the fail flag.

Two words are adjusted before they reach the engine. The reserved slot at 0Dh always contributes the constant 0100h, whatever the register file returns. The two self-clearing flush bits, bits 1:0 of the FIFO setup word at 0Fh, are forced to zero. While the walk runs, a busy flag mirrors the trigger bit and a lockout output blocks host register access. At the end of the walk the remainder is copied into a result register. Sticky done, fail and mode flags are then set and stay set until the status register is read.

The controller has five named states. IDLE waits for a trigger. ISSUE drives a read address. CAPTURE latches the returned word after the substitution step. SHIFT feeds 16 bits into the CRC. FINISH publishes the result and the status. The transitions are as follows. IDLE goes to ISSUE on a trigger. ISSUE always goes to CAPTURE, and CAPTURE always goes to SHIFT. SHIFT stays in SHIFT until its 16th bit, then goes to ISSUE, or to FINISH if the word just shifted was the last one. FINISH always returns to IDLE.

Top module: `regcrc_selftest`

## Requirements
- R1: The CRC uses polynomial 0x755B (x^16+x^14+x^13+x^12+x^10+x^8+x^6+x^4+x^3+x+1) with seed 0000h and no final XOR. Words enter MSB first. With the correct expected CRC stored at 3Fh, the result is 0000h and fail stays 0.
- R2: Reads are issued exactly once per run, in this order: 01h, 02h, 03h, 04h, 05h, 06h, 08h, 09h, 0Bh, 0Dh, 0Eh, 0Fh, 10h, 11h, 12h, 13h, 14h, 1Bh, 1Dh, 1Eh, 1Fh, 3Fh.
- R3: The word read at 0Dh is replaced by 0100h before it enters the CRC.
- R4: Bits 1:0 of the word read at 0Fh enter the CRC as 0. The other bits of that word enter the CRC unchanged.
- R5: A non-zero final remainder sets fail_o to 1, and result_o equals that remainder.
- R6: busy_o rises on the clock edge that samples start_i high in IDLE. It stays high for exactly 22*18+1 = 397 cycles, one ISSUE, one CAPTURE and 16 SHIFT cycles per word plus one FINISH cycle.
- R7: lock_o is high in every cycle that busy_o is high, and rf_rd_o is only asserted while lock_o is high.
- R8: result_o changes only at the end of a run. It holds its value while the block is idle.
- R9: At the end of a run, done_o and mode_o go to 1 and fail_o reflects the remainder. All three hold until a status_rd_i pulse clears them to 0. If a run ends in the same cycle as a status read, the new result wins.
- R10: A start_i pulse that arrives while a run is in progress is ignored. The run keeps its length and read count, and no second run follows.
- R11: After reset, busy_o, lock_o, rf_rd_o, done_o, fail_o and mode_o are 0 and result_o is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trigger pulse (host writes the trigger bit) |
| status_rd_i | input | 1 | Pulse when the host reads the status register; clears sticky flags |
| rf_rd_o | output | 1 | Register-file read strobe |
| rf_addr_o | output | 6 | Register-file read address |
| rf_data_i | input | 16 | Register-file read data, valid one cycle after the strobe |
| busy_o | output | 1 | Trigger bit readback, high while the test runs |
| lock_o | output | 1 | Host register access lockout |
| result_o | output | 16 | Final CRC remainder of the last run |
| done_o | output | 1 | Sticky test-complete flag |
| fail_o | output | 1 | Sticky non-zero-remainder flag |
| mode_o | output | 1 | Sticky mode flag, 1 for a register test |

## Verification
The bench builds its own register-file model and computes the expected remainder with a separate bit-serial CRC model. It targets the substitution corners. Garbage placed in the reserved slot, and flush bits set at 0Fh, must both still give a zero result. A design that skipped either substitution would report a false failure, while a design that masked too many bits would miss a real flip in bit 4 of 0Fh. The bench also checks the read order and count, the exact run length, and a re-trigger in mid-run. A sequencer that restarted on that trigger would give a longer run or extra reads. Finally it checks that the result holds while idle and that the sticky flags clear only on a status read.

// File: rtl/regcrc_pkg.sv
package regcrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CAPTURE,
        ST_SHIFT,
        ST_FINISH
    } seq_state_t;

    localparam int unsigned NUM_WORDS  = 22;
    localparam logic [15:0] CRC_POLY   = 16'h755B;
    localparam logic [7:0]  RSVD_ADDR  = 8'h0D;
    localparam logic [15:0] RSVD_VALUE = 16'h0100;
    localparam logic [7:0]  WSC_ADDR   = 8'h0F;
    localparam logic [15:0] WSC_MASK   = 16'h0003;

    // Ordered walk; the last slot holds the stored expected CRC.
    function automatic logic [7:0] walk_addr(input logic [4:0] idx);
        logic [7:0] a;
        unique case (idx)
            5'd0:    a = 8'h01;
            5'd1:    a = 8'h02;
            5'd2:    a = 8'h03;
            5'd3:    a = 8'h04;
            5'd4:    a = 8'h05;
            5'd5:    a = 8'h06;
            5'd6:    a = 8'h08;
            5'd7:    a = 8'h09;
            5'd8:    a = 8'h0B;
            5'd9:    a = 8'h0D;
            5'd10:   a = 8'h0E;
            5'd11:   a = 8'h0F;
            5'd12:   a = 8'h10;
            5'd13:   a = 8'h11;
            5'd14:   a = 8'h12;
            5'd15:   a = 8'h13;
            5'd16:   a = 8'h14;
            5'd17:   a = 8'h1B;
            5'd18:   a = 8'h1D;
            5'd19:   a = 8'h1E;
            5'd20:   a = 8'h1F;
            default: a = 8'h3F;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/regcrc_crc_serial.sv
module regcrc_crc_serial #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] POLY  = 16'h755B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] crc_o
);
    localparam logic [WIDTH-1:0] POLY_W = WIDTH'(POLY);

    logic [WIDTH-1:0] crc_q;
    logic             feedback;
    logic [WIDTH-1:0] crc_nx;

    always_comb begin
        feedback = crc_q[WIDTH-1] ^ bit_i;
        crc_nx   = {crc_q[WIDTH-2:0], 1'b0} ^ (feedback ? POLY_W : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear_i) begin
            crc_q <= '0;
        end else if (shift_i) begin
            crc_q <= crc_nx;
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/regcrc_word_shifter.sv
module regcrc_word_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             shift_i,
    output logic             msb_o
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= data_i;
        end else if (shift_i) begin
            word_q <= {word_q[WIDTH-2:0], 1'b0};
        end
    end

    assign msb_o = word_q[WIDTH-1];
endmodule

// File: rtl/regcrc_fixup.sv
module regcrc_fixup #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    import regcrc_pkg::*;

    localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'(RSVD_ADDR);
    localparam logic [ADDR_W-1:0] A_WSC  = ADDR_W'(WSC_ADDR);
    localparam logic [DATA_W-1:0] V_RSVD = DATA_W'(RSVD_VALUE);
    localparam logic [DATA_W-1:0] M_WSC  = DATA_W'(WSC_MASK);

    always_comb begin
        if (addr_i == A_RSVD) begin
            data_o = V_RSVD;
        end else if (addr_i == A_WSC) begin
            data_o = data_i & ~M_WSC;
        end else begin
            data_o = data_i;
        end
    end
endmodule

// File: rtl/regcrc_selftest.sv
module regcrc_selftest #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              status_rd_i,
    output logic              rf_rd_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              busy_o,
    output logic              lock_o,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              mode_o
);
    import regcrc_pkg::*;

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    seq_state_t        state_q, state_nx;
    logic [IDX_W-1:0]  idx_q;
    logic [BIT_W-1:0]  bit_q;
    logic              word_last, bit_last;
    logic              crc_clear, crc_shift, word_load;
    logic              msb;
    logic [DATA_W-1:0] fixed_word;
    logic [DATA_W-1:0] crc_val;

    assign word_last = (idx_q == IDX_LAST);
    assign bit_last  = (bit_q == BIT_LAST);
    assign rf_addr_o = ADDR_W'(walk_addr(5'(idx_q)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_nx = ST_ISSUE;
            ST_ISSUE:   state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (bit_last) state_nx = word_last ? ST_FINISH : ST_ISSUE;
            end
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        rf_rd_o   = 1'b0;
        busy_o    = 1'b1;
        crc_clear = 1'b0;
        crc_shift = 1'b0;
        word_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                crc_clear = start_i;
            end
            ST_ISSUE:   rf_rd_o   = 1'b1;
            ST_CAPTURE: word_load = 1'b1;
            ST_SHIFT:   crc_shift = 1'b1;
            ST_FINISH:  ;
            default:    busy_o    = 1'b0;
        endcase
        lock_o = busy_o;
    end

    // Word index and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            bit_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                idx_q <= '0;
                bit_q <= '0;
            end else if (crc_shift) begin
                if (bit_last) begin
                    bit_q <= '0;
                    if (!word_last) idx_q <= idx_q + IDX_W'(1);
                end else begin
                    bit_q <= bit_q + BIT_W'(1);
                end
            end
        end
    end

    // Result and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
            mode_o   <= 1'b0;
        end else if (state_q == ST_FINISH) begin
            result_o <= crc_val;
            done_o   <= 1'b1;
            fail_o   <= |crc_val;
            mode_o   <= 1'b1;
        end else if (status_rd_i) begin
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
            mode_o   <= 1'b0;
        end
    end

    regcrc_fixup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fixup (
        .addr_i (rf_addr_o),
        .data_i (rf_data_i),
        .data_o (fixed_word)
    );

    regcrc_word_shifter #(.WIDTH(DATA_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (word_load),
        .data_i  (fixed_word),
        .shift_i (crc_shift),
        .msb_o   (msb)
    );

    regcrc_crc_serial #(.WIDTH(DATA_W), .POLY(CRC_POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .shift_i (crc_shift),
        .bit_i   (msb),
        .crc_o   (crc_val)
    );
endmodule

// File: rtl/regcrc_selftest_chk.sv
module regcrc_selftest_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              status_rd_i,
    input logic              rf_rd_o,
    input logic              busy_o,
    input logic              lock_o,
    input logic [DATA_W-1:0] result_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              mode_o
);
    p_lock_covers_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> lock_o);

    p_read_under_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_o |-> lock_o);

    p_busy_needs_trigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    p_result_held_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(result_o));

    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (mode_o && !busy_o && $past(busy_o)));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !status_rd_i) |=> done_o);

    p_fail_implies_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    p_fail_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (result_o != '0));
endmodule

bind regcrc_selftest regcrc_selftest_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .status_rd_i (status_rd_i),
    .rf_rd_o     (rf_rd_o),
    .busy_o      (busy_o),
    .lock_o      (lock_o),
    .result_o    (result_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .mode_o      (mode_o)
);

// File: tb/regcrc_selftest_tb.sv
module regcrc_selftest_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        status_rd_i = 1'b0;
    logic        rf_rd_o;
    logic [5:0]  rf_addr_o;
    logic [15:0] rf_data_i;
    logic        busy_o, lock_o, done_o, fail_o, mode_o;
    logic [15:0] result_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [64];
    logic [7:0]  order [22];
    logic [7:0]  rd_log [64];
    int          nreads = 0;
    int          lock_viol = 0;

    always #5 clk = ~clk;

    regcrc_selftest u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_rd_i(status_rd_i),
        .rf_rd_o(rf_rd_o), .rf_addr_o(rf_addr_o), .rf_data_i(rf_data_i),
        .busy_o(busy_o), .lock_o(lock_o), .result_o(result_o),
        .done_o(done_o), .fail_o(fail_o), .mode_o(mode_o)
    );

    // Register file model with one cycle of read latency
    always @(posedge clk) begin
        if (rf_rd_o) begin
            rf_data_i <= mem[rf_addr_o];
            if (nreads < 64) rd_log[nreads] = {2'b00, rf_addr_o};
            nreads = nreads + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && ((busy_o && !lock_o) || (rf_rd_o && !lock_o)))
            lock_viol = lock_viol + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h755B;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [15:0] subst(input logic [7:0] a, input logic [15:0] v);
        if (a == 8'h0D) return 16'h0100;
        if (a == 8'h0F) return v & 16'hFFFC;
        return v;
    endfunction

    function automatic logic [15:0] model_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) c = crc_step(c, subst(order[i], mem[order[i][5:0]]));
        return c;
    endfunction

    task automatic load_defaults();
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[6'h02] = 16'h0036; mem[6'h03] = 16'h0B00; mem[6'h04] = 16'h8000;
        mem[6'h08] = 16'h8810; mem[6'h09] = 16'h0080; mem[6'h0D] = 16'h0100;
        mem[6'h0E] = 16'h0040; mem[6'h0F] = 16'h00F0; mem[6'h10] = 16'h8020;
        mem[6'h11] = 16'h0018; mem[6'h12] = 16'hFF00; mem[6'h13] = 16'hFF00;
        mem[6'h14] = 16'hFF00; mem[6'h1B] = 16'h00FF; mem[6'h1D] = 16'hEFDF;
        mem[6'h1E] = 16'hFFFF; mem[6'h1F] = 16'hFFFF;
        mem[6'h3F] = model_crc(21);
    endtask

    // Runs one test; retrig_at > 0 pulses start again in that busy cycle
    task automatic run_test(input int retrig_at, output int cycles);
        nreads = 0;
        lock_viol = 0;
        cycles = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && cycles < 2000) begin
            cycles = cycles + 1;
            start_i = (cycles == retrig_at);
            @(negedge clk);
        end
        start_i = 1'b0;
        if (cycles >= 2000) check(1'b0, "watchdog run", cycles, 397);
    endtask

    task automatic t_reset();
        check(!busy_o && !lock_o && !rf_rd_o, "R11 busy/lock/rd", {busy_o, lock_o, rf_rd_o}, 0);
        check(!done_o && !fail_o && !mode_o, "R11 status", {done_o, fail_o, mode_o}, 0);
        check(result_o == 16'h0000, "R11 result", result_o, 0);
    endtask

    task automatic t_good();
        int cyc;
        bit order_ok = 1'b1;
        load_defaults();
        run_test(0, cyc);
        check(cyc == 397, "R6 busy length", cyc, 397);
        check(result_o == 16'h0000 && !fail_o, "R1 zero remainder", result_o, 0);
        check(nreads == 22, "R2 read count", nreads, 22);
        for (int i = 0; i < 22; i++) if (rd_log[i] != order[i]) order_ok = 1'b0;
        check(order_ok, "R2 read order", order_ok, 1);
        check(lock_viol == 0, "R7 lockout", lock_viol, 0);
        check(done_o && mode_o, "R9 done/mode set", {done_o, mode_o}, 2'b11);
    endtask

    task automatic t_status_clear();
        logic [15:0] held = result_o;
        repeat (5) @(negedge clk);
        check(done_o && mode_o, "R9 sticky before read", {done_o, mode_o}, 2'b11);
        status_rd_i = 1'b1;
        @(negedge clk);
        status_rd_i = 1'b0;
        check(!done_o && !fail_o && !mode_o, "R9 cleared by read", {done_o, fail_o, mode_o}, 0);
        check(result_o == held, "R8 result after status read", result_o, held);
    endtask

    task automatic t_reserved();
        int cyc;
        load_defaults();
        mem[6'h0D] = 16'hABCD;
        run_test(0, cyc);
        check(result_o == 16'h0000 && !fail_o, "R3 reserved substituted", result_o, 0);
    endtask

    task automatic t_flush();
        int cyc;
        logic [15:0] exp;
        load_defaults();
        mem[6'h0F] = mem[6'h0F] | 16'h0003;
        run_test(0, cyc);
        check(result_o == 16'h0000 && !fail_o, "R4 flush bits ignored", result_o, 0);
        mem[6'h0F] = mem[6'h0F] ^ 16'h0010;
        exp = model_crc(22);
        run_test(0, cyc);
        check(fail_o && result_o == exp, "R4 other 0Fh bits used", result_o, exp);
    endtask

    task automatic t_corrupt();
        int cyc;
        logic [15:0] exp;
        load_defaults();
        mem[6'h05] = 16'h1234;
        exp = model_crc(22);
        run_test(0, cyc);
        check(fail_o == 1'b1 && exp != 0, "R5 fail flag", fail_o, 1);
        check(result_o == exp, "R5 remainder value", result_o, exp);
        mem[6'h05] = 16'h0000;
        repeat (30) @(negedge clk);
        check(result_o == exp, "R8 result held idle", result_o, exp);
    endtask

    task automatic t_retrigger();
        int cyc;
        load_defaults();
        run_test(50, cyc);
        check(cyc == 397, "R10 run length with retrigger", cyc, 397);
        check(nreads == 22, "R10 read count with retrigger", nreads, 22);
        repeat (20) @(negedge clk);
        check(!busy_o, "R10 no second run", busy_o, 0);
        check(result_o == 16'h0000, "R10 result intact", result_o, 0);
    endtask

    initial begin
        order = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h08, 8'h09, 8'h0B, 8'h0D, 8'h0E,
                  8'h0F, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h1B, 8'h1D, 8'h1E, 8'h1F, 8'h3F};
        load_defaults();
        rf_data_i = 16'h0000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_status_clear();
        t_reserved();
        t_flush();
        t_corrupt();
        t_retrigger();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule